// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer with Probe Registers

This block caches translations from a 20-bit linear page number to a 20-bit physical page number in 32 entries, arranged as 8 sets of 4 ways. The set is selected by linear address bits 14:12, which are the low three bits of the page number. A translation port answers one lookup per cycle, and its result is registered. An invalidate-all input empties the whole array in one cycle.

Two 32-bit probe registers give direct access to the array. The command register holds a linear page, a valid bit, three attribute pairs and an operation bit. The result register holds a physical page, the set's replacement-tree state, a placement/hit flag and a way number. Each write to the command register starts its operation on that same clock edge. Operation bit 0 installs an entry, and operation bit 1 searches the set. Both registers can be read at any time.

Replacement uses a three-bit pseudo-LRU tree per set. The tree bits are b0 (root), b1 (ways 0/1) and b2 (ways 2/3). When b0 is 0 the victim is in ways 0/1, chosen by b1. When b0 is 1 the victim is in ways 2/3, chosen by b2. Touching a way points the tree away from that way.

Top module: `xlat_buffer`

## Requirements
- R1: After synchronous reset, both registers read zero, `xl_hit` is 0 and every set's tree is 000.
- R2: Reserved bits read as zero whatever is written. Command bits 4:1 are reserved. In the result register, bits 11:10, 6:5 and 1:0 are reserved. The result register mask is 0xFFFFF39C.
- R3: A command write with bit 0 = 0 installs an entry in the set given by bits 14:12. The stored fields are page = bits 31:12, valid = bit 11, attributes = true bits 10, 8 and 6, and physical page = result bits 31:12. If result bit 4 is 1, the way is result bits 3:2.
- R4: If result bit 4 is 0 during an install, the tree's victim is used. From reset, four installs into one set fill ways 0, 2, 1, 3 in that order.
- R5: A command write with bit 0 = 1 that hits loads the result register as follows: physical page in bits 31:12, the tree state before the access in bits 9:7 (bit 7 = b0, bit 8 = b1, bit 9 = b2), a 1 in bit 4, and the lowest matching way in bits 3:2.
- R6: A search that misses loads zero into the result register.
- R7: A search compares the page and the valid bit (bit 11) exactly. Each attribute is compared through a pair: the true bit (10, 8, 6) accepts a stored 1, and the complement bit (9, 7, 5) accepts a stored 0. Setting both bits of a pair means the attribute is ignored.
- R8: One cycle after `xl_valid`, `xl_hit` reports whether a valid entry with page `xl_lin` exists, and `xl_phys` gives its physical page. Attributes are ignored here. `xl_hit` is 0 if `xl_valid` was 0.
- R9: A cycle with `inval_all` high leaves every entry invalid. This takes priority over an install in the same cycle.
- R10: Every install, search hit and translation hit makes the used way most recently used. A translation hit gives way only to a probe operation in the same cycle.
- R11: An automatic install into a full set evicts only the tree's victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = command register, 1 = result register |
| reg_wdata | input | 32 | Register write data |
| ctrl_rd | output | 32 | Command register contents |
| data_rd | output | 32 | Result register contents |
| xl_valid | input | 1 | Translation request |
| xl_lin | input | 20 | Linear page to translate |
| xl_hit | output | 1 | Registered translation hit |
| xl_phys | output | 20 | Registered physical page (0 on miss) |
| inval_all | input | 1 | Clear every valid bit |

## Verification
The placement order is checked with a fixed-way install and with a sequence of four automatic installs into an empty set. The automatic sequence tells a correct tree walk apart from round-robin or lowest-free allocation. Search patterns use exact attribute pairs, a pair that excludes the stored value, all-don't-care pairs, and a wrong valid bit. Together these separate true-bit matching from complement-bit matching, and show that the valid bit takes part in the compare. A translation hit followed by an automatic install shows whether translation hits move the tree. Without that update, the wrong entry is evicted.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int WAYS   = 4;          // tree logic below is written for four ways
  localparam int WAY_W  = 2;
  localparam int TREE_W = WAYS - 1;
  localparam int ATTR_W = 3;
  localparam logic [31:0] CMD_MASK = 32'hFFFF_FFE1;
  localparam logic [31:0] RES_MASK = 32'hFFFF_F39C;

  function automatic logic [WAY_W-1:0] plru_victim(input logic [TREE_W-1:0] t);
    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction

  function automatic logic [TREE_W-1:0] plru_touch(input logic [TREE_W-1:0] t,
                                                   input logic [WAY_W-1:0] w);
    logic [TREE_W-1:0] n;
    n = t;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction
endpackage

// File: rtl/xlat_lru_store.sv
module xlat_lru_store import xlat_pkg::*; #(
  parameter int SETS  = 8,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SET_W-1:0]  rd_set,
  output logic [TREE_W-1:0] rd_tree,
  input  logic              touch_en,
  input  logic [SET_W-1:0]  touch_set,
  input  logic [WAY_W-1:0]  touch_way
);
  logic [TREE_W-1:0] tree_q [SETS];

  assign rd_tree = tree_q[rd_set];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_en) begin
      tree_q[touch_set] <= plru_touch(tree_q[touch_set], touch_way);
    end
  end

  // R10: the way just used is never the next victim of its set
  assert_mru_not_victim_R10: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> plru_victim(tree_q[$past(touch_set)]) != $past(touch_way));
endmodule

// File: rtl/xlat_way.sv
module xlat_way import xlat_pkg::*; #(
  parameter int SETS   = 8,
  parameter int PAGE_W = 20,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inval,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic              wr_valid,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic [PAGE_W-1:0] wr_phys,
  input  logic [PAGE_W-1:0] pb_page,
  input  logic              pb_valid,
  input  logic [ATTR_W-1:0] pb_true,
  input  logic [ATTR_W-1:0] pb_comp,
  output logic              pb_hit,
  output logic [PAGE_W-1:0] pb_phys,
  input  logic [PAGE_W-1:0] tr_page,
  output logic              tr_hit,
  output logic [PAGE_W-1:0] tr_phys
);
  logic [PAGE_W-1:0] tag_mem  [SETS];
  logic [ATTR_W-1:0] attr_mem [SETS];
  logic [PAGE_W-1:0] phys_mem [SETS];
  logic [SETS-1:0]   vld_q;

  wire [SET_W-1:0] wr_set = wr_page[SET_W-1:0];
  wire [SET_W-1:0] pb_set = pb_page[SET_W-1:0];
  wire [SET_W-1:0] tr_set = tr_page[SET_W-1:0];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_set]  <= wr_page;
      attr_mem[wr_set] <= wr_attr;
      phys_mem[wr_set] <= wr_phys;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || inval)  vld_q <= '0;
    else if (wr_en)    vld_q[wr_set] <= wr_valid;
  end

  logic [ATTR_W-1:0] sa;
  always_comb begin
    sa = attr_mem[pb_set];
    pb_hit = (tag_mem[pb_set] == pb_page) && (vld_q[pb_set] == pb_valid) &&
             (((sa & pb_true) | (~sa & pb_comp)) == {ATTR_W{1'b1}});
    pb_phys = phys_mem[pb_set];
    tr_hit  = vld_q[tr_set] && (tag_mem[tr_set] == tr_page);
    tr_phys = phys_mem[tr_set];
  end

  // R9: a cycle of invalidate leaves no valid entry behind
  assert_inval_clears_R9: assert property (@(posedge clk) disable iff (rst)
    inval |=> vld_q == '0);
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer import xlat_pkg::*; #(
  parameter int SETS   = 8,
  parameter int PAGE_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       ctrl_rd,
  output logic [31:0]       data_rd,
  input  logic              xl_valid,
  input  logic [PAGE_W-1:0] xl_lin,
  output logic              xl_hit,
  output logic [PAGE_W-1:0] xl_phys,
  input  logic              inval_all
);
  localparam int SET_W = $clog2(SETS);

  logic [31:0] cmd_q, res_q;
  wire  [31:0] cw       = reg_wdata & CMD_MASK;
  wire         cmd_wr   = reg_wr_en && !reg_sel;
  wire         res_wr   = reg_wr_en && reg_sel;
  wire         op_write = cmd_wr && !cw[0];
  wire         op_probe = cmd_wr && cw[0];
  wire [PAGE_W-1:0] op_page = cw[31:32-PAGE_W];
  wire [SET_W-1:0]  op_set  = op_page[SET_W-1:0];
  wire [ATTR_W-1:0] op_true = {cw[10], cw[8], cw[6]};
  wire [ATTR_W-1:0] op_comp = {cw[9], cw[7], cw[5]};

  logic [TREE_W-1:0] op_tree;
  logic [WAY_W-1:0]  wr_way;
  assign wr_way = res_q[4] ? res_q[3:2] : plru_victim(op_tree);

  logic [WAYS-1:0]   pb_hit_v, tr_hit_v;
  logic [PAGE_W-1:0] pb_phys_v [WAYS];
  logic [PAGE_W-1:0] tr_phys_v [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    xlat_way #(.SETS(SETS), .PAGE_W(PAGE_W)) u_way (
      .clk(clk), .rst(rst), .inval(inval_all),
      .wr_en(op_write && (wr_way == WAY_W'(w))),
      .wr_page(op_page), .wr_valid(cw[11]), .wr_attr(op_true),
      .wr_phys(res_q[31:32-PAGE_W]),
      .pb_page(op_page), .pb_valid(cw[11]), .pb_true(op_true), .pb_comp(op_comp),
      .pb_hit(pb_hit_v[w]), .pb_phys(pb_phys_v[w]),
      .tr_page(xl_lin), .tr_hit(tr_hit_v[w]), .tr_phys(tr_phys_v[w]));
  end

  logic              pb_hit, tr_hit;
  logic [WAY_W-1:0]  pb_way, tr_way;
  logic [PAGE_W-1:0] pb_phys, tr_phys;
  always_comb begin
    pb_hit = 1'b0; pb_way = '0; pb_phys = '0;
    tr_hit = 1'b0; tr_way = '0; tr_phys = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (pb_hit_v[w]) begin
        pb_hit = 1'b1; pb_way = WAY_W'(w); pb_phys = pb_phys_v[w];
      end
      if (tr_hit_v[w]) begin
        tr_hit = 1'b1; tr_way = WAY_W'(w); tr_phys = tr_phys_v[w];
      end
    end
  end

  logic             touch_en;
  logic [SET_W-1:0] touch_set;
  logic [WAY_W-1:0] touch_way;
  always_comb begin
    touch_en = 1'b1; touch_set = op_set; touch_way = wr_way;
    if (op_probe) touch_way = pb_way;
    if (op_probe && !pb_hit) touch_en = 1'b0;
    if (!cmd_wr) begin
      touch_en  = xl_valid && tr_hit;
      touch_set = xl_lin[SET_W-1:0];
      touch_way = tr_way;
    end
  end

  xlat_lru_store #(.SETS(SETS)) u_lru (
    .clk(clk), .rst(rst), .rd_set(op_set), .rd_tree(op_tree),
    .touch_en(touch_en), .touch_set(touch_set), .touch_way(touch_way));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      res_q   <= '0;
      xl_hit  <= 1'b0;
      xl_phys <= '0;
    end else begin
      if (cmd_wr) cmd_q <= cw;
      if (res_wr) res_q <= reg_wdata & RES_MASK;
      else if (op_probe)
        res_q <= pb_hit ? ({pb_phys, {(32-PAGE_W){1'b0}}} |
                           {22'd0, op_tree, 2'b00, 1'b1, pb_way, 2'b00}) : '0;
      xl_hit  <= xl_valid && tr_hit;
      xl_phys <= (xl_valid && tr_hit) ? tr_phys : '0;
    end
  end

  assign ctrl_rd = cmd_q;
  assign data_rd = res_q;

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (cmd_q == '0 && res_q == '0 && !xl_hit));
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    ((cmd_q & ~CMD_MASK) == '0) && ((res_q & ~RES_MASK) == '0));
  assert_probe_hit_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (op_probe && pb_hit) |=> res_q[4]);
  assert_probe_miss_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (op_probe && !pb_hit) |=> res_q == '0);
  assert_no_idle_hit_R8: assert property (@(posedge clk) disable iff (rst)
    !xl_valid |=> !xl_hit);
endmodule

// File: tb/xlat_buffer_bench.sv
module xlat_buffer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] ctrl_rd, data_rd;
  logic        xl_valid = 1'b0;
  logic [19:0] xl_lin = '0;
  logic        xl_hit;
  logic [19:0] xl_phys;
  logic        inval_all = 1'b0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xlat_buffer u_xlat_buffer (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_res(input logic [31:0] v);
    @(negedge clk); reg_wr_en = 1; reg_sel = 1; reg_wdata = v;
    @(negedge clk); reg_wr_en = 0;
  endtask

  // pairs = {D, D#, U, U#, W, W#}
  task automatic cmd(input logic [19:0] pg, input logic v, input logic [5:0] pairs,
                     input logic op);
    @(negedge clk); reg_wr_en = 1; reg_sel = 0; reg_wdata = {pg, v, pairs, 4'b0, op};
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic xlate(input logic [19:0] pg, output logic hit, output logic [19:0] ph);
    @(negedge clk); xl_valid = 1; xl_lin = pg;
    @(negedge clk); xl_valid = 0; hit = xl_hit; ph = xl_phys;
  endtask

  task automatic t_reset;
    check("R1 ctrl", ctrl_rd, 0);
    check("R1 data", data_rd, 0);
    check("R1 hit", {31'd0, xl_hit}, 0);
  endtask

  task automatic t_reserved;
    set_res(32'hFFFF_FFFF);
    check("R2 data mask", data_rd, 32'hFFFF_F39C);
    cmd(20'hFFFFF, 1, 6'b111111, 1);
    check("R2 ctrl mask", ctrl_rd, 32'hFFFF_FFE1);
    check("R6 miss on empty", data_rd, 0);
  endtask

  task automatic t_fixed_way;
    logic h; logic [19:0] p;
    set_res({20'h12345, 12'h000} | 32'h18);
    cmd(20'h00A01, 1, 6'b100010, 0);
    cmd(20'h00A01, 1, 6'b100110, 1);
    check("R3 R5 fixed way probe", data_rd, 32'h1234_5218);
    cmd(20'h00A01, 1, 6'b010110, 1);
    check("R7 excluded attr misses", data_rd, 0);
    cmd(20'h00A01, 1, 6'b111111, 1);
    check("R7 dont care hits", data_rd, 32'h1234_5218);
    cmd(20'h00A01, 0, 6'b111111, 1);
    check("R7 valid bit compared", data_rd, 0);
    xlate(20'h00A01, h, p);
    check("R8 xlate hit", {11'd0, h, p}, {11'd0, 1'b1, 20'h12345});
    xlate(20'h00A09, h, p);
    check("R8 xlate miss", {11'd0, h, p}, 0);
  endtask

  task automatic t_auto_order;
    logic [19:0] pg [4] = '{20'h10003, 20'h20003, 20'h30003, 20'h40003};
    logic [31:0] expv [4] = '{32'h0000_0010, 32'h0000_0198, 32'h0000_0314, 32'h0000_029C};
    for (int i = 0; i < 4; i++) begin
      set_res({20'h11111 * (i + 1), 12'h000});
      cmd(pg[i], 1, 6'b000000, 0);
    end
    for (int i = 0; i < 4; i++) begin
      cmd(pg[i], 1, 6'b111111, 1);
      check("R4 R5 auto placement", data_rd, {20'h11111 * (i + 1), 12'h000} | expv[i]);
    end
  endtask

  task automatic t_lru_evict;
    logic h; logic [19:0] p;
    xlate(20'h10003, h, p);
    check("R10 xlate hit way0", {31'd0, h}, 1);
    set_res({20'h55555, 12'h000});
    cmd(20'h50003, 1, 6'b000000, 0);
    xlate(20'h20003, h, p);
    check("R11 victim evicted", {31'd0, h}, 0);
    xlate(20'h10003, h, p);
    check("R10 touched way kept", {11'd0, h, p}, {11'd0, 1'b1, 20'h11111});
    xlate(20'h50003, h, p);
    check("R11 new entry", {11'd0, h, p}, {11'd0, 1'b1, 20'h55555});
    xlate(20'h30003, h, p);
    check("R11 other way kept", {31'd0, h}, 1);
  endtask

  task automatic t_inval;
    logic h; logic [19:0] p;
    @(negedge clk); inval_all = 1;
    @(negedge clk); inval_all = 0;
    xlate(20'h00A01, h, p);
    check("R9 xlate after inval", {31'd0, h}, 0);
    cmd(20'h40003, 1, 6'b111111, 1);
    check("R9 probe after inval", data_rd, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_reserved;
    t_fixed_way;
    t_auto_order;
    t_lru_evict;
    t_inval;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule